// File: doc/BRIEF.md
# Dual-Modulus Main Feedback Divider

This block is the feedback divider chain of an integer-N frequency synthesizer, written as clocked digital logic. The input clock stands for the oscillator being divided. A prescaler stage divides that clock by 10 or by 11. A swallow counter picks the ratio for each prescaler cycle. A main counter counts prescaler cycles and emits one pulse per programmed output period. With the prescaler active the whole chain divides by 10·(M+1)+A. In bypass mode the prescaler and swallow counter stand still, and the main counter divides the input clock by M+1 on its own.

The programmed values are taken at each output period boundary. A counter-load control forces the counters to reload on every cycle while it is high. A power-down control freezes the whole chain in place. The modulus-select level is brought out as a port so the split between the two ratios can be observed.

Top module: `dmod_fb_divider`

## Requirements
- R1: With `bypass` low at the period's start, `fp` pulses once every 10·(M+1)+A input cycles, for legal values 1 ≤ M ≤ 511 and 0 ≤ A ≤ min(15, M+1).
- R2: With the prescaler active, `msel` is high in the first 11·A cycles of each output period and low in the remaining 10·(M+1−A) cycles.
- R3: With `bypass` high at the period's start, `fp` pulses once every M+1 input cycles, `a_val` has no effect, and `msel` stays low.
- R4: M = 1 gives the shortest periods: 2 cycles in bypass and 20 cycles with the prescaler active and A = 0.
- R5: `fp` is high for exactly one input cycle per period.
- R6: A change to `m_val`, `a_val` or `bypass` part way through a period leaves that period's length unchanged and applies from the next period.
- R7: While `pwr_dn` is high, `fp` is low, `msel` holds its value and no counting takes place. On release, counting resumes where it stopped, so the period grows by exactly the number of clock edges spent in power-down.
- R8: While `cnt_load` is high (and `pwr_dn` low), the counters reload from the inputs on every edge and `fp` stays low, even in the cycle where the period would have ended. The next pulse follows after one full period, counted from the last edge at which `cnt_load` was high.
- R9: During reset `fp` and `msel` are low. The first period starts at the third rising clock edge after `rst_n` is released, so the first pulse comes a full period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| m_val | input | M_W (9) | Main counter setting M |
| a_val | input | A_W (4) | Swallow counter setting A |
| bypass | input | 1 | High: prescaler skipped, divide by M+1 |
| pwr_dn | input | 1 | High: freeze all counting, no output pulse |
| cnt_load | input | 1 | High: reload counters from inputs on every edge |
| fp | output | 1 | One-cycle pulse at the end of each output period |
| msel | output | 1 | Modulus select: high while the prescaler divides by 11 |

## Verification
Two events can fall in the same cycle: the terminal count that would raise `fp`, and a `cnt_load` request that must win over it. To provoke the clash, the bench raises `cnt_load` in the very cycle where the running period is due to end. It judges the result in three ways. First, `fp` must read low in that cycle. Second, the scoreboard must never see a pulse it does not expect. Third, the next pulse must come a full period after the last load edge, built from the values that were present during the load. Power-down that falls in the middle of a period is judged in a similar way, by the stretched gap and by a frozen `msel`.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
  // Per-edge action for all counters of the chain
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } act_e;
endpackage

// File: rtl/dmod_ctrl.sv
module dmod_ctrl
  import dmod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic cnt_load,
  input  logic period_end,
  output act_e act,
  output logic fp
);
  logic run_q, run_d;

  // next-state
  always_comb begin
    run_d = run_q;
    act   = ACT_HOLD;
    if (!pwr_dn) begin
      run_d = 1'b1;
      if (!run_q || cnt_load || period_end) begin
        act = ACT_LOAD;
      end else begin
        act = ACT_STEP;
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  assign fp = run_q & ~pwr_dn & ~cnt_load & period_end;

  // R5
  fp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);

  // R9
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !pwr_dn) |=> run_q);
endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
  import dmod_pkg::*;
#(
  parameter int LO_DIV = 10,
  localparam int PW = $clog2(LO_DIV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  input  logic load_byp,
  input  logic load_hi,
  input  logic run_byp,
  input  logic roll_hi,
  output logic pre_tc
);
  localparam logic [PW-1:0] HI_LD = PW'(LO_DIV);
  localparam logic [PW-1:0] LO_LD = PW'(LO_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  // next-state: down-counter reloaded with 10 or 9 at every rollover
  always_comb begin
    pre_d = pre_q;
    unique case (act)
      ACT_LOAD: pre_d = load_byp ? '0 : (load_hi ? HI_LD : LO_LD);
      ACT_STEP: begin
        if (pre_q == '0) begin
          pre_d = run_byp ? '0 : (roll_hi ? HI_LD : LO_LD);
        end else begin
          pre_d = pre_q - PW'(1);
        end
      end
      default:  pre_d = pre_q;
    endcase
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  assign pre_tc = (pre_q == '0);

  // R7
  pre_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HOLD) |=> $stable(pre_q));

  // R2
  pre_modulus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && pre_tc && !run_byp) |=> (pre_q == HI_LD || pre_q == LO_LD));

  // R3
  pre_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && run_byp) |=> pre_tc);
endmodule

// File: rtl/dmod_swallow.sv
module dmod_swallow
  import dmod_pkg::*;
#(
  parameter int M_W = 9,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  act_e           act,
  input  logic           pre_tc,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic           bypass,
  output logic           run_byp,
  output logic           load_hi,
  output logic           roll_hi,
  output logic           period_end,
  output logic           msel
);
  logic [M_W-1:0] m_q, m_d;
  logic [A_W-1:0] a_q, a_d;
  logic           byp_q, byp_d;

  // next-state
  always_comb begin
    m_d   = m_q;
    a_d   = a_q;
    byp_d = byp_q;
    unique case (act)
      ACT_LOAD: begin
        m_d   = m_val;
        a_d   = bypass ? '0 : a_val;
        byp_d = bypass;
      end
      ACT_STEP: begin
        if (pre_tc && (m_q != '0)) begin
          m_d = m_q - M_W'(1);
          if (a_q != '0) begin
            a_d = a_q - A_W'(1);
          end
        end
      end
      default: begin
        m_d = m_q;
      end
    endcase
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      a_q   <= '0;
      byp_q <= 1'b0;
    end else begin
      m_q   <= m_d;
      a_q   <= a_d;
      byp_q <= byp_d;
    end
  end

  assign run_byp    = byp_q;
  assign load_hi    = !bypass && (a_val != '0);
  assign roll_hi    = (a_q > A_W'(1));
  assign period_end = pre_tc && (m_q == '0);
  assign msel       = !byp_q && (a_q != '0);

  // R3
  byp_noswallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q |-> (a_q == '0));

  // R1
  m_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && pre_tc && m_q != '0) |=> (m_q == $past(m_q) - M_W'(1)));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act != ACT_LOAD) |=> $stable(byp_q));
endmodule

// File: rtl/dmod_fb_divider.sv
module dmod_fb_divider
  import dmod_pkg::*;
#(
  parameter int M_W    = 9,
  parameter int A_W    = 4,
  parameter int LO_DIV = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic           bypass,
  input  logic           pwr_dn,
  input  logic           cnt_load,
  output logic           fp,
  output logic           msel
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  act_e act;
  logic pre_tc, run_byp, load_hi, roll_hi, period_end;

  dmod_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pwr_dn     (pwr_dn),
    .cnt_load   (cnt_load),
    .period_end (period_end),
    .act        (act),
    .fp         (fp)
  );

  dmod_prescaler #(.LO_DIV(LO_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .act      (act),
    .load_byp (bypass),
    .load_hi  (load_hi),
    .run_byp  (run_byp),
    .roll_hi  (roll_hi),
    .pre_tc   (pre_tc)
  );

  dmod_swallow #(.M_W(M_W), .A_W(A_W)) u_swl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .act        (act),
    .pre_tc     (pre_tc),
    .m_val      (m_val),
    .a_val      (a_val),
    .bypass     (bypass),
    .run_byp    (run_byp),
    .load_hi    (load_hi),
    .roll_hi    (roll_hi),
    .period_end (period_end),
    .msel       (msel)
  );

  // R7
  pd_msel_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pwr_dn |=> $stable(msel));
endmodule

// File: tb/dmod_fb_divider_tb_top.sv
module dmod_fb_divider_tb_top;
  localparam int WD_LIM = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] m_val = 9'd1;
  logic [3:0] a_val = 4'd0;
  logic       bypass = 1'b0;
  logic       pwr_dn = 1'b0;
  logic       cnt_load = 1'b0;
  logic       fp, msel;

  always #5 clk = ~clk;

  dmod_fb_divider dut_i (
    .clk(clk), .rst_n(rst_n), .m_val(m_val), .a_val(a_val), .bypass(bypass),
    .pwr_dn(pwr_dn), .cnt_load(cnt_load), .fp(fp), .msel(msel)
  );

  typedef struct {
    int    gap;
    int    mcnt;
    string rg;
    string rm;
  } item_t;

  item_t exp_q[$];
  item_t it;
  int    cyc = 0;
  int    ref_cyc = 0;
  int    mcnt = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    prev_fp = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", rq, what, act, expv, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      if (!pwr_dn && msel) mcnt++;
      if (fp) begin
        chk(!prev_fp, "R5", "pulse width", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected pulse", 1, 0);
        end else begin
          it = exp_q.pop_front();
          chk((cyc - ref_cyc) == it.gap, it.rg, "period", cyc - ref_cyc, it.gap);
          chk(mcnt == it.mcnt, it.rm, "msel cycles", mcnt, it.mcnt);
        end
        ref_cyc = cyc;
        mcnt = 0;
      end
      prev_fp = fp;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == WD_LIM && !done) begin
      chk(1'b0, "R1", "watchdog expired", cyc, WD_LIM);
      report();
    end
  end

  task automatic push(input int m, input int a, input bit b, input string rg, input int extra);
    item_t x;
    x.gap  = (b ? (m + 1) : (10 * (m + 1) + a)) + extra;
    x.mcnt = b ? 0 : 11 * a;
    x.rg   = rg;
    x.rm   = b ? "R3" : "R2";
    exp_q.push_back(x);
  endtask

  task automatic wait_fp();
    do @(negedge clk); while (fp !== 1'b1);
  endtask

  // called at a negedge whose next rising edge is a load edge
  task automatic run_cfg(input int m, input int a, input bit b, input string rg);
    m_val = 9'(m);
    a_val = 4'(a);
    bypass = b;
    push(m, a, b, rg, 0);
    wait_fp();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(fp == 1'b0, "R9", "fp in reset", int'(fp), 0);
    chk(msel == 1'b0, "R9", "msel in reset", int'(msel), 0);
    rst_n = 1'b1;
    ref_cyc = cyc + 2;
    mcnt = 0;
    mon_on = 1'b1;
    run_cfg(1, 0, 0, "R9");          // 20 cycles, first period after reset
    run_cfg(1, 0, 0, "R4");          // shortest prescaled
    run_cfg(1, 2, 0, "R1");          // A = M+1
    run_cfg(5, 3, 0, "R1");
    run_cfg(20, 15, 0, "R1");        // largest A
    run_cfg(1, 0, 1, "R4");          // shortest bypass = 2
    run_cfg(6, 9, 1, "R3");          // a_val ignored in bypass

    // R6: mid-period change applies only to the next period
    m_val = 9'd3; a_val = 4'd1; bypass = 1'b0;
    push(3, 1, 0, "R6", 0);
    repeat (10) @(negedge clk);
    m_val = 9'd2; a_val = 4'd0; bypass = 1'b1;
    push(2, 0, 1, "R6", 0);
    wait_fp();
    wait_fp();

    // R7: power-down in mid-period for 9 edges
    begin
      logic held;
      m_val = 9'd4; a_val = 4'd2; bypass = 1'b0;
      push(4, 2, 0, "R7", 9);
      repeat (7) @(negedge clk);
      pwr_dn = 1'b1;
      held = msel;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(fp == 1'b0, "R7", "fp during power-down", int'(fp), 0);
        chk(msel == held, "R7", "msel frozen", int'(msel), int'(held));
      end
      @(negedge clk);
      pwr_dn = 1'b0;
      wait_fp();
    end

    // R8: counter-load raised exactly in the terminal cycle
    m_val = 9'd2; a_val = 4'd1; bypass = 1'b0;   // 31-cycle period, not pushed
    repeat (31) @(negedge clk);
    cnt_load = 1'b1;
    #1;
    chk(fp == 1'b0, "R8", "fp suppressed by load", int'(fp), 0);
    m_val = 9'd6; a_val = 4'd2;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      #1;
      chk(fp == 1'b0, "R8", "fp while loading", int'(fp), 0);
    end
    @(negedge clk);
    cnt_load = 1'b0;
    ref_cyc = cyc - 1;
    mcnt = 0;
    push(6, 2, 0, "R8", 0);
    wait_fp();

    run_cfg(511, 15, 0, "R1");       // longest prescaled period
    run_cfg(511, 0, 1, "R3");        // longest bypass period
    run_cfg(9, 7, 0, "R2");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "pulses outstanding", exp_q.size(), 0);
    report();
  end
endmodule